// File: doc/BRIEF.md
# Verified SPI Register Read Sequencer

This block is the controller side of a guarded single-register read from a slave on a shared SPI chain. A request names a 2-bit device address, a 5-bit register address and a mode. The sequencer then drives chip-select, the serial clock and the output data line. It runs the command, filler and count bytes and collects the register value. In verified mode it goes on to echo the value back and exchange a control byte. It compares every address echo and decodes the slave's acknowledge. It returns the data with a 2-bit outcome code.

The serial link uses mode 0. The clock idles low, the controller changes its output after a falling edge, and the slave's line is sampled on the rising edge. Bytes are sent most significant bit first. One bit lasts `CLK_DIV` system clocks, and `CLK_DIV` must be even. Requests and responses use valid/ready handshakes. At most one transfer is in flight.

Top module: `spi_vread_seq`

## Requirements
- R1: The first byte sent is the command {dev[1:0], reg[4:0], 1'b1}, most significant bit first. The serial clock is low whenever chip-select is inactive (high).
- R2: While chip-select is active, each serial clock level lasts exactly `CLK_DIV/2` system clocks.
- R3: The second byte sent is 0x00. If the byte received during it differs from the command, chip-select is released after that byte. The response then carries status 1 (address mismatch) and checked flag 0.
- R4: The third byte sent is 0x0F (count-minus-one in the upper nibble, its inverse below). The byte received during it is the register value.
- R5: In fast mode, chip-select is released after the third byte. The response carries status 0, checked flag 0 and the register value.
- R6: In verified mode, the fourth byte sent is the register value just received. If the byte received during it differs from the command, the transfer ends after four bytes with status 1 and checked flag 0.
- R7: The fifth byte sent is 0x59. The received byte decides the status: 0x59 gives 0 (ok), 0xA6 gives 2 (slave error), and any other value gives 3 (protocol error). The checked flag is 1 in all three cases, and the data output holds the register value.
- R8: A response is offered only after chip-select has been released. Chip-select stays inactive for at least `CLK_DIV` system clocks between transfers.
- R9: `req_ready` is high only when no transfer or response is pending. Chip-select falls only in the cycle after a request is accepted. A response holds its data, status and flag stable until `rsp_ready` is high.
- R10: After reset, chip-select is high, the serial clock is low, `req_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_dev | input | 2 | Device address on the chain |
| req_reg | input | 5 | Register address |
| req_fast | input | 1 | 1: stop after the data byte; 0: full verified sequence |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken when high together with rsp_valid |
| rsp_data | output | 8 | Register value received |
| rsp_status | output | 2 | 0 ok, 1 address mismatch, 2 slave error, 3 protocol error |
| rsp_checked | output | 1 | 1 when the status comes from the control byte exchange |
| spi_cs_n | output | 1 | Chip-select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Controller-to-slave data |
| spi_miso | input | 1 | Slave-to-controller data |

## Verification
The hardest outcomes to reach from the ports are the late ones: an address echo that goes bad only in the fourth byte, and a control byte that is neither 0x59 nor 0xA6. A healthy slave never produces either. The bench therefore uses a behavioural slave that can be told, per transfer, to corrupt the first echo or the second echo, or to force a chosen control byte. Each of these faults is applied in both fast and verified modes where it applies. The bytes the slave receives are logged and checked against the truncated sequence expected for each outcome.

// File: rtl/spi_vread_seq.sv
module spi_vread_seq #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_dev,
  input  logic [4:0] req_reg,
  input  logic       req_fast,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  output logic [1:0] rsp_status,
  output logic       rsp_checked,
  output logic       spi_cs_n,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] HALF_END = CW'(HALF - 1);
  localparam logic [CW-1:0] GAP_END = CW'(CLK_DIV - 1);
  localparam logic [1:0] ST_OK = 2'd0, ST_ADDR = 2'd1, ST_SLV = 2'd2, ST_PROTO = 2'd3;
  localparam logic [7:0] CTL_GOOD = 8'h59, CTL_BAD = 8'hA6;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP, S_RESP} state_t;
  state_t state;

  logic [CW-1:0] cnt;
  logic          ph;
  logic [2:0]    bit_cnt, byte_idx;
  logic [7:0]    tx_sh, rx_sh, cmd;
  logic          fast;

  wire half_done = (cnt == HALF_END);
  wire byte_done = half_done && ph && (bit_cnt == 3'd7);

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_RESP);
  assign spi_mosi  = tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; ph <= 1'b0; bit_cnt <= '0; byte_idx <= '0;
      tx_sh <= '0; rx_sh <= '0; cmd <= '0; fast <= 1'b0;
      spi_cs_n <= 1'b1; spi_sclk <= 1'b0;
      rsp_data <= '0; rsp_status <= ST_OK; rsp_checked <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          state <= S_XFER; spi_cs_n <= 1'b0; spi_sclk <= 1'b0;
          cnt <= '0; ph <= 1'b0; bit_cnt <= '0; byte_idx <= '0;
          cmd <= {req_dev, req_reg, 1'b1}; tx_sh <= {req_dev, req_reg, 1'b1};
          fast <= req_fast; rsp_data <= '0; rsp_checked <= 1'b0; rsp_status <= ST_OK;
        end
        S_XFER: begin
          cnt <= half_done ? '0 : cnt + 1'b1;
          if (half_done && !ph) begin
            spi_sclk <= 1'b1; ph <= 1'b1;
            rx_sh <= {rx_sh[6:0], spi_miso};
          end else if (half_done && ph) begin
            spi_sclk <= 1'b0; ph <= 1'b0;
            bit_cnt <= bit_cnt + 1'b1;
            if (!byte_done) tx_sh <= {tx_sh[6:0], 1'b0};
          end
          if (byte_done) begin
            byte_idx <= byte_idx + 1'b1;
            case (byte_idx)
              3'd0: tx_sh <= 8'h00;
              3'd1: if (rx_sh != cmd) begin
                      state <= S_GAP; spi_cs_n <= 1'b1; cnt <= '0; rsp_status <= ST_ADDR;
                    end else tx_sh <= 8'h0F;
              3'd2: begin
                      rsp_data <= rx_sh;
                      if (fast) begin
                        state <= S_GAP; spi_cs_n <= 1'b1; cnt <= '0;
                      end else tx_sh <= rx_sh;
                    end
              3'd3: if (rx_sh != cmd) begin
                      state <= S_GAP; spi_cs_n <= 1'b1; cnt <= '0; rsp_status <= ST_ADDR;
                    end else tx_sh <= CTL_GOOD;
              default: begin
                      state <= S_GAP; spi_cs_n <= 1'b1; cnt <= '0; rsp_checked <= 1'b1;
                      rsp_status <= (rx_sh == CTL_GOOD) ? ST_OK :
                                    (rx_sh == CTL_BAD)  ? ST_SLV : ST_PROTO;
                    end
            endcase
          end
        end
        S_GAP: begin
          cnt <= cnt + 1'b1;
          if (cnt == GAP_END) state <= S_RESP;
        end
        default: if (rsp_ready) state <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R1
  AST_CS_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(req_valid && req_ready)); // R9
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_status) && $stable(rsp_checked)); // R9
  AST_RSP_CS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> spi_cs_n && !req_ready); // R8
  AST_CHECKED_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status[1] |-> rsp_checked); // R7
endmodule

// File: tb/spi_vread_seq_tb.sv
module spi_vread_seq_tb_top;
  localparam int DIV = 4;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_fast = 1'b0, rsp_ready = 1'b0;
  logic [1:0] req_dev = '0;
  logic [4:0] req_reg = '0;
  logic req_ready, rsp_valid, rsp_checked, spi_cs_n, spi_sclk, spi_mosi, spi_miso;
  logic [7:0] rsp_data;
  logic [1:0] rsp_status;

  always #2 clk = ~clk;

  spi_vread_seq #(.CLK_DIV(DIV)) dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_dev, .req_reg, .req_fast,
    .rsp_valid, .rsp_ready, .rsp_data, .rsp_status, .rsp_checked,
    .spi_cs_n, .spi_sclk, .spi_mosi, .spi_miso);

  int n_cmp = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural slave
  logic [7:0] mem [32];
  logic [7:0] out_sh = 8'hFF, rx_b = 8'h00, s_cmd = 8'h00, s_data = 8'h00;
  int nb = 0, bidx = 0;
  bit bad_echo1 = 0, bad_echo2 = 0, force_ctl = 0, load = 0;
  logic [7:0] ctl_val = 8'h00, pend = 8'h00;
  logic [7:0] mq [$];
  assign spi_miso = out_sh[7];

  always @(posedge spi_sclk or negedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      out_sh = 8'hFF; nb = 0; bidx = 0; load = 0;
    end else if (spi_sclk) begin
      rx_b = {rx_b[6:0], spi_mosi};
      nb++;
      if (nb == 8) begin
        nb = 0; mq.push_back(rx_b);
        case (bidx)
          0: begin s_cmd = rx_b; pend = bad_echo1 ? (rx_b ^ 8'h01) : rx_b; end
          1: begin s_data = mem[s_cmd[5:1]]; pend = s_data; end
          2: pend = bad_echo2 ? (s_cmd ^ 8'h80) : s_cmd;
          default: pend = force_ctl ? ctl_val : ((rx_b == s_data) ? 8'h59 : 8'hA6);
        endcase
        bidx++; load = 1;
      end
    end else begin
      if (load) begin out_sh = pend; load = 0; end
      else out_sh = {out_sh[6:0], 1'b1};
    end
  end

  // per-clock reference comparison
  bit busy = 0, prev_sclk = 0, prev_cs = 1;
  int lvl = 0, gap = 1000;
  always @(negedge clk) if (rst_n) begin
    chk(req_ready == !busy, "R9 req_ready vs model", req_ready, !busy);
    if (!busy) chk(spi_cs_n && !rsp_valid, "R9 idle outputs", {spi_cs_n, rsp_valid}, 2);
    if (spi_cs_n) chk(!spi_sclk, "R1 sclk idle low", spi_sclk, 0);
    if (rsp_valid) chk(spi_cs_n, "R8 cs released at response", spi_cs_n, 1);
    if (prev_cs && !spi_cs_n) begin
      chk(gap >= DIV, "R8 cs gap", gap, DIV);
      lvl = 1;
    end else if (!spi_cs_n && spi_sclk != prev_sclk) begin
      chk(lvl == HALF, "R2 sclk level length", lvl, HALF);
      lvl = 1;
    end else lvl++;
    gap = spi_cs_n ? gap + 1 : 0;
    prev_cs = spi_cs_n; prev_sclk = spi_sclk;
    if (req_valid && req_ready) busy = 1;
    if (rsp_valid && rsp_ready) busy = 0;
  end

  task automatic do_read(input logic [1:0] dv, input logic [4:0] rg, input bit fst,
                         input int hold, input logic [1:0] e_st, input bit e_chk,
                         input int e_n, input string tag);
    logic [7:0] c, d;
    logic [7:0] ex [5];
    c = {dv, rg, 1'b1}; d = mem[rg];
    ex[0] = c; ex[1] = 8'h00; ex[2] = 8'h0F; ex[3] = d; ex[4] = 8'h59;
    mq.delete();
    @(posedge clk); #1;
    req_valid = 1; req_dev = dv; req_reg = rg; req_fast = fst;
    @(posedge clk); #1;
    req_valid = 0;
    do @(negedge clk); while (!rsp_valid);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_status == e_st, {tag, " R9 response held"}, rsp_status, e_st);
    end
    chk(rsp_status == e_st, {tag, " status"}, rsp_status, e_st);
    chk(rsp_checked == e_chk, {tag, " checked flag"}, rsp_checked, e_chk);
    if (e_st != 2'd1) chk(rsp_data == d, {tag, " data R4"}, rsp_data, d);
    chk(mq.size() == e_n, {tag, " byte count"}, mq.size(), e_n);
    for (int i = 0; i < e_n && i < mq.size(); i++)
      chk(mq[i] == ex[i], $sformatf("%s R1 byte %0d sent", tag, i), mq[i], ex[i]);
    @(posedge clk); #1 rsp_ready = 1;
    @(posedge clk); #1 rsp_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 8'(i * 29 + 17);
    mem[5] = 8'h3C; mem[31] = 8'hA5; mem[0] = 8'h00; mem[1] = 8'hFF;
    repeat (3) @(negedge clk);
    chk(spi_cs_n && !spi_sclk && req_ready && !rsp_valid, "R10 reset state",
        {spi_cs_n, spi_sclk, req_ready, rsp_valid}, 4'b1010);
    rst_n = 1;
    repeat (2) @(negedge clk);
    do_read(2'd2, 5'd5, 0, 0, 2'd0, 1, 5, "R7 verified ok");
    do_read(2'd1, 5'd31, 1, 3, 2'd0, 0, 3, "R5 fast read");
    bad_echo1 = 1;
    do_read(2'd3, 5'd7, 0, 0, 2'd1, 0, 2, "R3 echo1 bad verified");
    do_read(2'd0, 5'd9, 1, 2, 2'd1, 0, 2, "R3 echo1 bad fast");
    bad_echo1 = 0; bad_echo2 = 1;
    do_read(2'd1, 5'd12, 0, 0, 2'd1, 0, 4, "R6 echo2 bad");
    do_read(2'd1, 5'd12, 1, 0, 2'd0, 0, 3, "R5 fast ignores echo2");
    bad_echo2 = 0; force_ctl = 1; ctl_val = 8'hA6;
    do_read(2'd2, 5'd20, 0, 4, 2'd2, 1, 5, "R7 slave error");
    ctl_val = 8'h00;
    do_read(2'd3, 5'd3, 0, 0, 2'd3, 1, 5, "R7 protocol error");
    ctl_val = 8'h58;
    do_read(2'd0, 5'd17, 0, 0, 2'd3, 1, 5, "R7 near-miss control");
    force_ctl = 0;
    do_read(2'd0, 5'd0, 0, 0, 2'd0, 1, 5, "R4 zero data");
    do_read(2'd3, 5'd1, 0, 0, 2'd0, 1, 5, "R4 ones data");
    do_read(2'd3, 5'd1, 1, 0, 2'd0, 0, 3, "R5 fast back to back");
    repeat (10) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule